// File: doc/BRIEF.md
# Strobed Serial Command Front End for a Display Controller

This block is the host-facing front end of a fluorescent display controller. A host moves three lines, an active-low strobe, a shift clock and a data line, and the block turns them into configuration register updates and display RAM writes. All three lines are brought into the system clock domain through synchronisers, and the block finds shift-clock edges there by oversampling, so the system clock must run several times faster than the shift clock.

Each strobe-low period is one frame. Bits are taken on rising shift-clock edges, least significant bit first. The first complete byte of a frame is a command whose two top bits pick one of four classes: display mode, data setting, display control or address setting. All later bytes in the frame are data. In write mode they go to the display RAM port at the current address, which then advances or stays put, and bytes are dropped while the address is out of range. When a data-setting command asks for a key read, the frame instead shifts a key-data vector out on falling shift-clock edges through an open-drain style drive-low enable.

Top module: `vfd_cmd_if`

## Requirements
- R1: After reset the display mode is 100 (eight digits), dimming code 000, display off, transfer mode 00, auto-increment, test flag clear, address 00h and valid, and the drive-low enable deasserted.
- R2: A command with bits 7:6 = 00 loads the display mode from bits 2:0; bits 5:3 have no effect.
- R3: A command with bits 7:6 = 10 sets the display enable from bit 3 and the dimming code from bits 2:0; bits 5:4 have no effect.
- R4: A command with bits 7:6 = 01 loads the transfer mode from bits 1:0 (00 write display, 10 read keys), the fixed-address flag from bit 2 and the test flag from bit 3; bits 5:4 have no effect.
- R5: A command with bits 7:6 = 11 loads the address from bits 3:0 and marks it valid only when bits 5:4 are 00; otherwise the address is invalid.
- R6: In write mode with auto-increment, each data byte is written at the current address and the address then advances by one; a write at 0Fh makes the address invalid, so later bytes are dropped.
- R7: With the fixed-address flag set, every data byte is written at the same address.
- R8: While the address is invalid no RAM write occurs, across frames, until an address command with a valid value arrives.
- R9: Raising the strobe before a byte is complete discards the partial bits, and the next frame starts again with a command byte.
- R10: Shift-clock edges while the strobe is high change no register and cause no write.
- R11: In a frame opened by a key-read data-setting command, the n-th falling shift-clock edge after the command presents key bit n-1 (bit 0 first, wrapping after the last bit); the drive-low enable is asserted when that bit is 0 and deasserted when it is 1, and is deasserted before the first falling edge and whenever the strobe is high.
- R12: Data bytes received in a key-read frame cause no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stb_n_i | input | 1 | Frame strobe, active low, asynchronous |
| sck_i | input | 1 | Serial shift clock, asynchronous |
| sdi_i | input | 1 | Serial data in, LSB first |
| key_bits_i | input | KEY_BITS | Key data to shift out, bit 0 first |
| dout_low_o | output | 1 | Drive-low enable for the open-drain data output |
| ram_we_o | output | 1 | Display RAM write strobe, one cycle |
| ram_addr_o | output | ADDR_W | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |
| disp_mode_o | output | 3 | Display mode code |
| dim_code_o | output | 3 | Dimming code |
| disp_on_o | output | 1 | Display enable |
| xfer_mode_o | output | 2 | Transfer mode |
| addr_fixed_o | output | 1 | Fixed-address flag |
| test_mode_o | output | 1 | Test flag |

## Verification
A table of one-byte command frames walks the three configuration classes with both meaningful and don't-care bits set, so a decoder that reads a wrong bit field or confuses two classes shows a wrong register value. Multi-byte frames starting near the top of the address space separate auto-increment, fixed addressing, the end-of-range cutoff and the sticky invalid address. Truncated bytes and clocks sent with the strobe high show whether stale bits leak into the next frame, and a key-read frame with a mixed bit pattern tells apart bit order, edge choice and polarity of the drive-low enable while proving its data bytes never reach the RAM.

// File: rtl/vfdif_pkg.sv
package vfdif_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        CLS_MODE = 2'b00,
        CLS_DATA = 2'b01,
        CLS_CTRL = 2'b10,
        CLS_ADDR = 2'b11
    } cmd_class_e;

    localparam logic [1:0] XFER_WRITE = 2'b00;
    localparam logic [1:0] XFER_KEYRD = 2'b10;

    localparam logic [2:0] MODE_RESET = 3'b100;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] dim;
        logic       on;
        logic [1:0] xfer;
        logic       fixed;
        logic       test;
    } cfg_t;

    typedef struct packed {
        logic              sck_prev;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              first;
        logic              bvalid;
        logic [BYTE_W-1:0] bdata;
        logic              bfirst;
    } rx_state_t;

endpackage

// File: rtl/vfdif_sync.sv
module vfdif_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= RESET_VAL;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/vfdif_rx.sv
module vfdif_rx
    import vfdif_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sck_fall_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_first_o
);

    rx_state_t q, d;
    logic      sck_rise;

    assign sck_rise   = sck_i & ~q.sck_prev & ~stb_n_i;
    assign sck_fall_o = ~sck_i & q.sck_prev & ~stb_n_i;

    always_comb begin
        d          = q;
        d.sck_prev = sck_i;
        d.bvalid   = 1'b0;
        if (stb_n_i) begin
            d.cnt   = '0;
            d.first = 1'b1;
            d.shreg = '0;
        end else if (sck_rise) begin
            d.shreg = {sdi_i, q.shreg[BYTE_W-1:1]};
            if (q.cnt == CNT_W'(BYTE_W-1)) begin
                d.bvalid = 1'b1;
                d.bdata  = {sdi_i, q.shreg[BYTE_W-1:1]};
                d.bfirst = q.first;
                d.first  = 1'b0;
                d.cnt    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.first    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_valid_o = q.bvalid;
    assign byte_o       = q.bdata;
    assign byte_first_o = q.bfirst;

    // R10: a high strobe never lets a byte through
    assert_idle_no_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_n_i |=> !q.bvalid);

    // R9: after the strobe was high, the next byte is a command
    assert_first_after_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_n_i |=> q.first);

endmodule

// File: rtl/vfdif_decode.sv
module vfdif_decode
    import vfdif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_active_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_first_i,
    output cfg_t              cfg_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              rd_frame_o
);

    localparam int FIELD_W = 6;

    typedef struct packed {
        cfg_t              cfg;
        logic [ADDR_W-1:0] addr;
        logic              addr_ok;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [BYTE_W-1:0] wdata;
        logic              rd_frame;
    } dec_state_t;

    dec_state_t q, d;
    logic [FIELD_W-1:0] addr_field;
    logic               data_accept;

    assign addr_field  = byte_i[FIELD_W-1:0];
    assign data_accept = (q.cfg.xfer == XFER_WRITE) && !q.rd_frame && q.addr_ok;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (!frame_active_i) d.rd_frame = 1'b0;
        if (byte_valid_i) begin
            if (byte_first_i) begin
                unique case (cmd_class_e'(byte_i[7:6]))
                    CLS_MODE: d.cfg.mode = byte_i[2:0];
                    CLS_DATA: begin
                        d.cfg.xfer  = byte_i[1:0];
                        d.cfg.fixed = byte_i[2];
                        d.cfg.test  = byte_i[3];
                        d.rd_frame  = (byte_i[1:0] == XFER_KEYRD);
                    end
                    CLS_CTRL: begin
                        d.cfg.dim = byte_i[2:0];
                        d.cfg.on  = byte_i[3];
                    end
                    CLS_ADDR: begin
                        d.addr    = addr_field[ADDR_W-1:0];
                        d.addr_ok = ((addr_field >> ADDR_W) == '0);
                    end
                    default: ;
                endcase
            end else if (data_accept) begin
                d.we    = 1'b1;
                d.waddr = q.addr;
                d.wdata = byte_i;
                if (!q.cfg.fixed) begin
                    if (&q.addr) d.addr_ok = 1'b0;
                    else         d.addr    = q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.cfg.mode <= MODE_RESET;
            q.addr_ok  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cfg_o      = q.cfg;
    assign we_o       = q.we;
    assign waddr_o    = q.waddr;
    assign wdata_o    = q.wdata;
    assign rd_frame_o = q.rd_frame;

    // R8: a data byte at an invalid address produces no write
    assert_drop_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_i && !byte_first_i && !q.addr_ok) |=> !q.we);

    // R7: fixed addressing keeps the address across data bytes
    assert_fixed_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_i && !byte_first_i && q.cfg.fixed) |=> (q.addr == $past(q.addr)));

    // R6: an accepted byte below the top address advances it by one
    assert_auto_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_i && !byte_first_i && data_accept && !q.cfg.fixed && !(&q.addr))
        |=> (q.addr == ADDR_W'($past(q.addr) + 1'b1)));

    // R12: no write while a key-read frame is open
    assert_no_write_in_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.rd_frame |=> !q.we);

endmodule

// File: rtl/vfdif_keytx.sv
module vfdif_keytx #(
    parameter int KEY_BITS = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rd_en_i,
    input  logic                sck_fall_i,
    input  logic [KEY_BITS-1:0] key_bits_i,
    output logic                drive_low_o
);

    localparam int PTR_W = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             drive_low;
    } tx_state_t;

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (!rd_en_i) begin
            d.ptr       = '0;
            d.drive_low = 1'b0;
        end else if (sck_fall_i) begin
            d.drive_low = ~key_bits_i[q.ptr];
            d.ptr       = (q.ptr == PTR_W'(KEY_BITS-1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign drive_low_o = q.drive_low;

    // R11: output is released whenever no read frame is open
    assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !q.drive_low);

    // R11: the drive level changes only on a falling shift edge
    assert_hold_between_edges_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !sck_fall_i) |=> $stable(q.drive_low));

endmodule

// File: rtl/vfd_cmd_if.sv
module vfd_cmd_if
    import vfdif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int KEY_BITS    = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                stb_n_i,
    input  logic                sck_i,
    input  logic                sdi_i,
    input  logic [KEY_BITS-1:0] key_bits_i,
    output logic                dout_low_o,
    output logic                ram_we_o,
    output logic [ADDR_W-1:0]   ram_addr_o,
    output logic [BYTE_W-1:0]   ram_wdata_o,
    output logic [2:0]          disp_mode_o,
    output logic [2:0]          dim_code_o,
    output logic                disp_on_o,
    output logic [1:0]          xfer_mode_o,
    output logic                addr_fixed_o,
    output logic                test_mode_o
);

    logic [2:0]        pins_sync;
    logic              stb_n_s, sck_s, sdi_s;
    logic              sck_fall;
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_first;
    logic              rd_frame;
    cfg_t              cfg;

    vfdif_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({stb_n_i, sck_i, sdi_i}),
        .sync_o  (pins_sync)
    );

    assign {stb_n_s, sck_s, sdi_s} = pins_sync;

    vfdif_rx i_rx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stb_n_i      (stb_n_s),
        .sck_i        (sck_s),
        .sdi_i        (sdi_s),
        .sck_fall_o   (sck_fall),
        .byte_valid_o (byte_valid),
        .byte_o       (byte_data),
        .byte_first_o (byte_first)
    );

    vfdif_decode #(
        .ADDR_W (ADDR_W)
    ) i_decode (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .frame_active_i (~stb_n_s),
        .byte_valid_i   (byte_valid),
        .byte_i         (byte_data),
        .byte_first_i   (byte_first),
        .cfg_o          (cfg),
        .we_o           (ram_we_o),
        .waddr_o        (ram_addr_o),
        .wdata_o        (ram_wdata_o),
        .rd_frame_o     (rd_frame)
    );

    vfdif_keytx #(
        .KEY_BITS (KEY_BITS)
    ) i_keytx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_en_i     (rd_frame),
        .sck_fall_i  (sck_fall),
        .key_bits_i  (key_bits_i),
        .drive_low_o (dout_low_o)
    );

    assign disp_mode_o  = cfg.mode;
    assign dim_code_o   = cfg.dim;
    assign disp_on_o    = cfg.on;
    assign xfer_mode_o  = cfg.xfer;
    assign addr_fixed_o = cfg.fixed;
    assign test_mode_o  = cfg.test;

    // R1: configuration leaves its reset values only through a command byte
    assert_cfg_by_command_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(byte_valid && byte_first) |=> $stable(cfg));

endmodule

// File: tb/test_vfd_cmd_if.sv
`timescale 1ns/1ps
module test_vfd_cmd_if;

    localparam int HP       = 8;
    localparam int KEY_BITS = 16;
    localparam int NVEC     = 8;

    // {command byte, expected {mode, dim, on, xfer, fixed, test}}
    localparam logic [18:0] VEC [NVEC] = '{
        {8'h03, 11'b011_000_0_00_0_0},
        {8'h38, 11'b000_000_0_00_0_0},
        {8'h8D, 11'b000_101_1_00_0_0},
        {8'hB2, 11'b000_010_0_00_0_0},
        {8'h4C, 11'b000_010_0_00_1_1},
        {8'h72, 11'b000_010_0_10_0_0},
        {8'h40, 11'b000_010_0_00_0_0},
        {8'h04, 11'b100_010_0_00_0_0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb_n = 1'b1;
    logic sck = 1'b1;
    logic sdi = 1'b0;
    logic [KEY_BITS-1:0] key_bits = 16'hA5C3;
    logic dout_low, ram_we, disp_on, addr_fixed, test_mode;
    logic [3:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [2:0] disp_mode, dim_code;
    logic [1:0] xfer_mode;
    logic [10:0] cfg_obs;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int wr_cnt = 0;
    logic [3:0] wr_addr [64];
    logic [7:0] wr_data [64];

    always #2.5 clk = ~clk;

    vfd_cmd_if i_vfd_cmd_if (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .stb_n_i      (stb_n),
        .sck_i        (sck),
        .sdi_i        (sdi),
        .key_bits_i   (key_bits),
        .dout_low_o   (dout_low),
        .ram_we_o     (ram_we),
        .ram_addr_o   (ram_addr),
        .ram_wdata_o  (ram_wdata),
        .disp_mode_o  (disp_mode),
        .dim_code_o   (dim_code),
        .disp_on_o    (disp_on),
        .xfer_mode_o  (xfer_mode),
        .addr_fixed_o (addr_fixed),
        .test_mode_o  (test_mode)
    );

    assign cfg_obs = {disp_mode, dim_code, disp_on, xfer_mode, addr_fixed, test_mode};

    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            wr_addr[wr_cnt % 64] = ram_addr;
            wr_data[wr_cnt % 64] = ram_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            sdi = b[i];
            wait_clk(HP);
            sck = 1'b1;
            wait_clk(HP);
        end
    endtask

    task automatic open_frame();
        stb_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic close_frame();
        wait_clk(HP);
        stb_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic cmd_frame(input logic [7:0] b);
        open_frame();
        send_bits(b, 8);
        close_frame();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        check(cfg_obs == 11'b100_000_0_00_0_0, "R1 reset cfg", cfg_obs, 11'b100_000_0_00_0_0);
        check(dout_low == 1'b0, "R1 reset dout", dout_low, 0);

        // R2 R3 R4: command table
        for (int v = 0; v < NVEC; v++) begin
            cmd_frame(VEC[v][18:11]);
            check(cfg_obs == VEC[v][10:0], "R2/R3/R4 command vector", cfg_obs, VEC[v][10:0]);
        end

        // R6: auto-increment from 0Eh, cut off after 0Fh
        cmd_frame(8'h40);
        base = wr_cnt;
        open_frame();
        send_bits(8'hCE, 8);
        send_bits(8'hA1, 8);
        send_bits(8'hB2, 8);
        send_bits(8'hC3, 8);
        close_frame();
        check(wr_cnt - base == 2, "R6 write count", wr_cnt - base, 2);
        check({wr_addr[base], wr_data[base]} == 12'hEA1, "R6 first write",
              {wr_addr[base], wr_data[base]}, 12'hEA1);
        check({wr_addr[base+1], wr_data[base+1]} == 12'hFB2, "R6 second write",
              {wr_addr[base+1], wr_data[base+1]}, 12'hFB2);

        // R7: fixed address
        cmd_frame(8'h44);
        base = wr_cnt;
        open_frame();
        send_bits(8'hC3, 8);
        send_bits(8'h11, 8);
        send_bits(8'h22, 8);
        close_frame();
        check(wr_cnt - base == 2, "R7 write count", wr_cnt - base, 2);
        check({wr_addr[base], wr_data[base], wr_addr[base+1], wr_data[base+1]} == 24'h311322,
              "R7 fixed writes",
              {wr_addr[base], wr_data[base], wr_addr[base+1], wr_data[base+1]}, 24'h311322);

        // R5 R8: address with bits 5:4 set is invalid and stays so across frames
        cmd_frame(8'h40);
        base = wr_cnt;
        open_frame();
        send_bits(8'hD5, 8);
        send_bits(8'h55, 8);
        close_frame();
        open_frame();
        send_bits(8'h40, 8);
        send_bits(8'h56, 8);
        close_frame();
        check(wr_cnt - base == 0, "R5 R8 invalid address drops data", wr_cnt - base, 0);
        open_frame();
        send_bits(8'hC7, 8);
        send_bits(8'h66, 8);
        close_frame();
        check(wr_cnt - base == 1, "R5 valid address restores writes", wr_cnt - base, 1);
        check({wr_addr[base], wr_data[base]} == 12'h766, "R5 write at 07h",
              {wr_addr[base], wr_data[base]}, 12'h766);

        // R9: partial byte discarded on strobe rise
        base = wr_cnt;
        open_frame();
        send_bits(8'hC2, 8);
        send_bits(8'h99, 5);
        close_frame();
        check(wr_cnt - base == 0, "R9 partial byte not written", wr_cnt - base, 0);
        cmd_frame(8'h8F);
        check(cfg_obs == 11'b100_111_1_00_0_0, "R9 next frame starts with command",
              cfg_obs, 11'b100_111_1_00_0_0);

        // R10: clocks with strobe high are ignored
        base = wr_cnt;
        send_bits(8'h3A, 8);
        send_bits(8'hC5, 8);
        wait_clk(4 * HP);
        check(cfg_obs == 11'b100_111_1_00_0_0, "R10 cfg unchanged", cfg_obs, 11'b100_111_1_00_0_0);
        check(wr_cnt - base == 0, "R10 no write", wr_cnt - base, 0);
        open_frame();
        send_bits(8'hC9, 8);
        send_bits(8'h5A, 8);
        close_frame();
        check(wr_cnt - base == 1 && wr_addr[base] == 4'h9 && wr_data[base] == 8'h5A,
              "R10 clean frame afterwards", {wr_addr[base], wr_data[base]}, 12'h95A);

        // R11 R12: key read frame
        base = wr_cnt;
        open_frame();
        send_bits(8'h42, 8);
        wait_clk(HP);
        check(dout_low == 1'b0, "R11 released before first fall", dout_low, 0);
        for (int k = 0; k < KEY_BITS; k++) begin
            sck = 1'b0;
            sdi = 1'b1;
            wait_clk(HP);
            check(dout_low == ~key_bits[k], "R11 key bit", dout_low, ~key_bits[k]);
            sck = 1'b1;
            wait_clk(HP);
        end
        sck = 1'b0;
        wait_clk(HP);
        check(dout_low == ~key_bits[0], "R11 wrap to bit 0", dout_low, ~key_bits[0]);
        sck = 1'b1;
        wait_clk(HP);
        close_frame();
        check(dout_low == 1'b0, "R11 released after strobe", dout_low, 0);
        check(wr_cnt - base == 0, "R12 no write in read frame", wr_cnt - base, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule